// File: doc/BRIEF.md
# Delay Line Configuration Sequencer

This block drives the control pins of a programmable delay line that shifts the sampling clock of a high-speed receiver. It offers two operations, and only one of them runs at a time. A bring-up operation powers the line up, resets it, programs a frequency-range code and waits for the line to report lock. A phase-load operation parks the clock-data-recovery logic, writes a new 4-bit tap selection as reflected Gray code, re-enables the clock output and hands control back to the recovery loop.

The range code comes from a clock-rate input given in MHz. Every wait on a status bit returns from the delay line with a timeout counted in microsecond ticks. Each operation ends with a single-cycle completion pulse that carries a failure flag. Higher-level tuning logic uses the block by sweeping phases, choosing a tap and loading it again. The delay line itself sits outside the block.

Top module: `dlc_seq`

## Requirements
- R1: After reset, every control output is low, the power-save output equals its reset parameter (default 0), and the frequency and phase outputs are 0. `busy`, `done` and `fail` are low.
- R2: The frequency code latched during bring-up is 0 for rates up to 112 MHz. It rises by one past each ceiling of 125, 137, 150, 162, 175 and 187 MHz. It is 7 for 188 to 200 MHz and stays saturated at 7 above 200 MHz.
- R3: Bring-up changes the outputs in this order: power save off, reset high, power-down high, frequency code loaded, reset low, power-down low, enable high, clock-out enable high.
- R4: Bring-up completes without failure once the lock status reads high.
- R5: If lock does not appear within `TIMEOUT_US` microsecond ticks of the clock-out enable being set, bring-up ends with `fail` set. In that case power save is not restored.
- R6: A successful bring-up restores power save only if it was on when the request was taken. While the block is idle, `psave_load` writes `psave_val` into power save.
- R7: Phase load first drives clock-data-recovery enable and clock-out enable low, and drives external recovery enable and line enable high. It then waits for the clock-out status to read low. If the status is still high after `TIMEOUT_US` ticks, the load fails and the phase output is left unchanged.
- R8: The phase output takes the reflected Gray code of the requested index. Indices 0 to 15 map to 0,1,3,2,6,7,5,4,12,13,15,14,10,11,9,8.
- R9: After the Gray write, clock-out enable is set and the block waits for the clock-out status to read high. If that fails to happen within `TIMEOUT_US` ticks, the load ends with `fail` and recovery enable stays low.
- R10: A successful phase load ends by setting recovery enable and clearing external recovery enable, in the same cycle as `done`.
- R11: While `busy` is high, new init, phase and power-save-load requests are ignored. When init and phase requests arrive in the same idle cycle, init wins.
- R12: `busy` is high for the whole operation and falls in the cycle that `done` pulses. `done` lasts one cycle, and `fail` is only ever high together with `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| us_tick | input | 1 | One-cycle pulse every microsecond |
| rate_mhz | input | RATE_W | Sampling clock rate in MHz |
| init_req | input | 1 | Start a bring-up operation |
| phase_req | input | 1 | Start a phase-load operation |
| phase_sel | input | PH_W | Binary phase index for phase load |
| psave_load | input | 1 | Write power save while idle |
| psave_val | input | 1 | Power-save value for `psave_load` |
| lock_sts | input | 1 | Lock status from the delay line |
| clkout_sts | input | 1 | Clock-out enable read back from the delay line |
| dl_rst | output | 1 | Delay-line reset |
| dl_pdn | output | 1 | Delay-line power-down |
| dl_en | output | 1 | Delay-line enable |
| dl_clkout_en | output | 1 | Clock-out enable |
| dl_cdr_en | output | 1 | Clock-data-recovery enable |
| dl_cdr_ext_en | output | 1 | External (fixed-phase) recovery enable |
| dl_psave | output | 1 | Power save |
| dl_freq | output | FREQ_W | Frequency-range code |
| dl_gray | output | PH_W | Gray-coded phase selection |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| fail | output | 1 | Failure flag, valid with `done` |

## Verification
Some properties of the control outputs are checked by the assertions on every cycle:
- the frequency code moves only while reset and power-down are both held;
- power-down is released only after reset;
- clock-out enable rises only on an enabled, powered line;
- the phase changes only while clock output and recovery are parked;
- the two recovery enables are never both on;
- `done`, `fail` and `busy` keep their pulse relationship.

Other behaviour can only be shown by the bench scenarios, which compare the full ordered list of output changes against expectations. Those scenarios cover the exact step order, the range codes at each ceiling, all sixteen Gray values, the conditional power-save restore, the timeout length at each of the three wait points, and the dropping of requests that arrive while busy.

// File: rtl/dlc_pkg.sv
package dlc_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_I_PSOFF,
      ST_I_RST,
      ST_I_PDN,
      ST_I_FREQ,
      ST_I_UNRST,
      ST_I_UNPDN,
      ST_I_EN,
      ST_I_CLK,
      ST_I_WLOCK,
      ST_P_PREP,
      ST_P_WLOW,
      ST_P_GRAY,
      ST_P_CLK,
      ST_P_WHIGH,
      ST_P_FIN
   } seq_state_e;

   // Ceiling in MHz of range k: base plus half-MHz steps, rounded up
   function automatic int range_ceiling(input int base_mhz, input int step_x2, input int k);
      return base_mhz + (step_x2 * k + 1) / 2;
   endfunction

endpackage

// File: rtl/dlc_rate_enc.sv
module dlc_rate_enc
   import dlc_pkg::*;
#(
   parameter int RATE_W   = 8,
   parameter int FREQ_W   = 3,
   parameter int BASE_MHZ = 112,
   parameter int STEP_X2  = 25
) (
   input  logic [RATE_W-1:0] rate,
   output logic [FREQ_W-1:0] code
);
   localparam int NCEIL = (1 << FREQ_W) - 1;

   logic [NCEIL-1:0] above;

   generate
      for (genvar k = 0; k < NCEIL; k++) begin : g_cmp
         localparam int CEIL = range_ceiling(BASE_MHZ, STEP_X2, k);
         assign above[k] = (32'(rate) > CEIL);
      end
   endgenerate

   // Count of exceeded ceilings; saturates naturally at NCEIL
   always_comb begin
      code = '0;
      for (int k = 0; k < NCEIL; k++) begin
         code = code + FREQ_W'(above[k]);
      end
   end

endmodule

// File: rtl/dlc_wait_timer.sv
module dlc_wait_timer #(
   parameter int TIMEOUT_US = 50
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic tick,
   output logic expired
);
   localparam int CNT_W = $clog2(TIMEOUT_US + 1);

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (start) begin
         cnt <= CNT_W'(TIMEOUT_US);
      end else if (tick && (cnt != '0)) begin
         cnt <= cnt - 1'b1;
      end
   end

   assign expired = (cnt == '0);

endmodule

// File: rtl/dlc_gray_enc.sv
module dlc_gray_enc #(
   parameter int PH_W = 4,
   parameter int IMPL = 0
) (
   input  logic [PH_W-1:0] bin,
   output logic [PH_W-1:0] gray
);
   generate
      if (IMPL == 0) begin : g_shift
         assign gray = bin ^ (bin >> 1);
      end else begin : g_bitwise
         for (genvar b = 0; b < PH_W; b++) begin : g_bit
            if (b == PH_W - 1) begin : g_msb
               assign gray[b] = bin[b];
            end else begin : g_low
               assign gray[b] = bin[b] ^ bin[b+1];
            end
         end
      end
   endgenerate

endmodule

// File: rtl/dlc_ctrl_fsm.sv
module dlc_ctrl_fsm
   import dlc_pkg::*;
#(
   parameter int PH_W      = 4,
   parameter int FREQ_W    = 3,
   parameter bit PSAVE_RST = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              init_req,
   input  logic              phase_req,
   input  logic [PH_W-1:0]   phase_sel,
   input  logic              psave_load,
   input  logic              psave_val,
   input  logic              lock_sts,
   input  logic              clkout_sts,
   input  logic [FREQ_W-1:0] freq_code,
   input  logic [PH_W-1:0]   gray_code,
   input  logic              tmr_expired,
   output logic              tmr_start,
   output logic [PH_W-1:0]   phase_q,
   output logic              dl_rst,
   output logic              dl_pdn,
   output logic              dl_en,
   output logic              dl_clkout_en,
   output logic              dl_cdr_en,
   output logic              dl_cdr_ext_en,
   output logic              dl_psave,
   output logic [FREQ_W-1:0] dl_freq,
   output logic [PH_W-1:0]   dl_gray,
   output logic              busy,
   output logic              done,
   output logic              fail
);
   seq_state_e state;
   logic       ps_saved;

   // Timer reloads on the edge that enters each wait state
   assign tmr_start = (state == ST_I_CLK) || (state == ST_P_PREP) || (state == ST_P_CLK);
   assign busy      = (state != ST_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state         <= ST_IDLE;
         phase_q       <= '0;
         ps_saved      <= 1'b0;
         dl_psave      <= PSAVE_RST;
         dl_rst        <= 1'b0;
         dl_pdn        <= 1'b0;
         dl_en         <= 1'b0;
         dl_clkout_en  <= 1'b0;
         dl_cdr_en     <= 1'b0;
         dl_cdr_ext_en <= 1'b0;
         dl_freq       <= '0;
         dl_gray       <= '0;
         done          <= 1'b0;
         fail          <= 1'b0;
      end else begin
         done <= 1'b0;
         fail <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (init_req) begin
                  ps_saved <= dl_psave;
                  state    <= ST_I_PSOFF;
               end else if (phase_req) begin
                  phase_q <= phase_sel;
                  state   <= ST_P_PREP;
               end else if (psave_load) begin
                  dl_psave <= psave_val;
               end
            end
            ST_I_PSOFF: begin
               dl_psave <= 1'b0;
               state    <= ST_I_RST;
            end
            ST_I_RST: begin
               dl_rst <= 1'b1;
               state  <= ST_I_PDN;
            end
            ST_I_PDN: begin
               dl_pdn <= 1'b1;
               state  <= ST_I_FREQ;
            end
            ST_I_FREQ: begin
               dl_freq <= freq_code;
               state   <= ST_I_UNRST;
            end
            ST_I_UNRST: begin
               dl_rst <= 1'b0;
               state  <= ST_I_UNPDN;
            end
            ST_I_UNPDN: begin
               dl_pdn <= 1'b0;
               state  <= ST_I_EN;
            end
            ST_I_EN: begin
               dl_en <= 1'b1;
               state <= ST_I_CLK;
            end
            ST_I_CLK: begin
               dl_clkout_en <= 1'b1;
               state        <= ST_I_WLOCK;
            end
            ST_I_WLOCK: begin
               if (lock_sts) begin
                  dl_psave <= ps_saved;
                  done     <= 1'b1;
                  state    <= ST_IDLE;
               end else if (tmr_expired) begin
                  done  <= 1'b1;
                  fail  <= 1'b1;
                  state <= ST_IDLE;
               end
            end
            ST_P_PREP: begin
               dl_cdr_en     <= 1'b0;
               dl_clkout_en  <= 1'b0;
               dl_cdr_ext_en <= 1'b1;
               dl_en         <= 1'b1;
               state         <= ST_P_WLOW;
            end
            ST_P_WLOW: begin
               if (!clkout_sts) begin
                  state <= ST_P_GRAY;
               end else if (tmr_expired) begin
                  done  <= 1'b1;
                  fail  <= 1'b1;
                  state <= ST_IDLE;
               end
            end
            ST_P_GRAY: begin
               dl_gray <= gray_code;
               state   <= ST_P_CLK;
            end
            ST_P_CLK: begin
               dl_clkout_en <= 1'b1;
               state        <= ST_P_WHIGH;
            end
            ST_P_WHIGH: begin
               if (clkout_sts) begin
                  state <= ST_P_FIN;
               end else if (tmr_expired) begin
                  done  <= 1'b1;
                  fail  <= 1'b1;
                  state <= ST_IDLE;
               end
            end
            ST_P_FIN: begin
               dl_cdr_en     <= 1'b1;
               dl_cdr_ext_en <= 1'b0;
               done          <= 1'b1;
               state         <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/dlc_seq.sv
module dlc_seq
   import dlc_pkg::*;
#(
   parameter int RATE_W     = 8,
   parameter int FREQ_W     = 3,
   parameter int PH_W       = 4,
   parameter int BASE_MHZ   = 112,
   parameter int STEP_X2    = 25,
   parameter int TIMEOUT_US = 50,
   parameter int GRAY_IMPL  = 0,
   parameter bit PSAVE_RST  = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              us_tick,
   input  logic [RATE_W-1:0] rate_mhz,
   input  logic              init_req,
   input  logic              phase_req,
   input  logic [PH_W-1:0]   phase_sel,
   input  logic              psave_load,
   input  logic              psave_val,
   input  logic              lock_sts,
   input  logic              clkout_sts,
   output logic              dl_rst,
   output logic              dl_pdn,
   output logic              dl_en,
   output logic              dl_clkout_en,
   output logic              dl_cdr_en,
   output logic              dl_cdr_ext_en,
   output logic              dl_psave,
   output logic [FREQ_W-1:0] dl_freq,
   output logic [PH_W-1:0]   dl_gray,
   output logic              busy,
   output logic              done,
   output logic              fail
);
   localparam int TOP_CEIL = range_ceiling(BASE_MHZ, STEP_X2, (1 << FREQ_W) - 2);

   initial begin
      assert (TIMEOUT_US > 0) else $error("TIMEOUT_US must be positive");
      assert (TOP_CEIL < (1 << RATE_W)) else $error("RATE_W too narrow for range ceilings");
      assert (PH_W > 0 && FREQ_W > 0) else $error("field widths must be positive");
      assert (GRAY_IMPL == 0 || GRAY_IMPL == 1) else $error("GRAY_IMPL must be 0 or 1");
   end

   logic [FREQ_W-1:0] freq_code;
   logic [PH_W-1:0]   phase_q;
   logic [PH_W-1:0]   gray_code;
   logic              tmr_start;
   logic              tmr_expired;

   dlc_rate_enc #(
      .RATE_W   (RATE_W),
      .FREQ_W   (FREQ_W),
      .BASE_MHZ (BASE_MHZ),
      .STEP_X2  (STEP_X2)
   ) u_rate (
      .rate (rate_mhz),
      .code (freq_code)
   );

   dlc_gray_enc #(
      .PH_W (PH_W),
      .IMPL (GRAY_IMPL)
   ) u_gray (
      .bin  (phase_q),
      .gray (gray_code)
   );

   dlc_wait_timer #(
      .TIMEOUT_US (TIMEOUT_US)
   ) u_tmr (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (tmr_start),
      .tick    (us_tick),
      .expired (tmr_expired)
   );

   dlc_ctrl_fsm #(
      .PH_W      (PH_W),
      .FREQ_W    (FREQ_W),
      .PSAVE_RST (PSAVE_RST)
   ) u_fsm (
      .clk           (clk),
      .rst_n         (rst_n),
      .init_req      (init_req),
      .phase_req     (phase_req),
      .phase_sel     (phase_sel),
      .psave_load    (psave_load),
      .psave_val     (psave_val),
      .lock_sts      (lock_sts),
      .clkout_sts    (clkout_sts),
      .freq_code     (freq_code),
      .gray_code     (gray_code),
      .tmr_expired   (tmr_expired),
      .tmr_start     (tmr_start),
      .phase_q       (phase_q),
      .dl_rst        (dl_rst),
      .dl_pdn        (dl_pdn),
      .dl_en         (dl_en),
      .dl_clkout_en  (dl_clkout_en),
      .dl_cdr_en     (dl_cdr_en),
      .dl_cdr_ext_en (dl_cdr_ext_en),
      .dl_psave      (dl_psave),
      .dl_freq       (dl_freq),
      .dl_gray       (dl_gray),
      .busy          (busy),
      .done          (done),
      .fail          (fail)
   );

endmodule

// File: rtl/dlc_seq_sva.sv
module dlc_seq_sva #(
   parameter int FREQ_W = 3,
   parameter int PH_W   = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              dl_rst,
   input logic              dl_pdn,
   input logic              dl_en,
   input logic              dl_clkout_en,
   input logic              dl_cdr_en,
   input logic              dl_cdr_ext_en,
   input logic              dl_psave,
   input logic [FREQ_W-1:0] dl_freq,
   input logic [PH_W-1:0]   dl_gray,
   input logic              busy,
   input logic              done,
   input logic              fail
);
   AST_FREQ_UNDER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(dl_freq) |-> (dl_rst && dl_pdn)); // R3
   AST_PDN_AFTER_RST: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dl_pdn) |-> !dl_rst); // R3
   AST_PSAVE_OFF_AT_RST: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dl_rst) |-> !dl_psave); // R3
   AST_CLKOUT_RISE_OK: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dl_clkout_en) |-> (dl_en && !dl_rst && !dl_pdn)); // R9
   AST_GRAY_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(dl_gray) |-> (!dl_clkout_en && !dl_cdr_en && dl_cdr_ext_en)); // R7
   AST_CDR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      dl_cdr_en |-> !dl_cdr_ext_en); // R10
   AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R12
   AST_FAIL_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      fail |-> done); // R12
   AST_BUSY_ENDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done); // R12
endmodule

bind dlc_seq dlc_seq_sva #(.FREQ_W(FREQ_W), .PH_W(PH_W)) u_sva (
   .clk           (clk),
   .rst_n         (rst_n),
   .dl_rst        (dl_rst),
   .dl_pdn        (dl_pdn),
   .dl_en         (dl_en),
   .dl_clkout_en  (dl_clkout_en),
   .dl_cdr_en     (dl_cdr_en),
   .dl_cdr_ext_en (dl_cdr_ext_en),
   .dl_psave      (dl_psave),
   .dl_freq       (dl_freq),
   .dl_gray       (dl_gray),
   .busy          (busy),
   .done          (done),
   .fail          (fail)
);

// File: tb/dlc_seq_tb.sv
`timescale 1ns/1ps
module dlc_seq_tb;
   localparam int TO_US    = 50;
   localparam int TICK_DIV = 4;

   typedef struct {
      logic [7:0] code;
      string      req;
   } ev_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       us_tick = 1'b0;
   logic [7:0] rate_mhz = '0;
   logic       init_req = 1'b0, phase_req = 1'b0, psave_load = 1'b0, psave_val = 1'b0;
   logic [3:0] phase_sel = '0;
   logic       lock_sts, clkout_sts;
   logic       dl_rst, dl_pdn, dl_en, dl_clkout_en, dl_cdr_en, dl_cdr_ext_en, dl_psave;
   logic [2:0] dl_freq;
   logic [3:0] dl_gray;
   logic       busy, done, fail;

   int n_tests = 0, n_fail = 0;
   ev_t exp_q[$];
   int  m_val[9];
   int  prv[9];
   bit  mon_init = 1'b0;
   bit  finished = 1'b0;

   always #4 clk = ~clk;

   dlc_seq #(.TIMEOUT_US(TO_US)) u_dut (
      .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .rate_mhz(rate_mhz),
      .init_req(init_req), .phase_req(phase_req), .phase_sel(phase_sel),
      .psave_load(psave_load), .psave_val(psave_val),
      .lock_sts(lock_sts), .clkout_sts(clkout_sts),
      .dl_rst(dl_rst), .dl_pdn(dl_pdn), .dl_en(dl_en), .dl_clkout_en(dl_clkout_en),
      .dl_cdr_en(dl_cdr_en), .dl_cdr_ext_en(dl_cdr_ext_en), .dl_psave(dl_psave),
      .dl_freq(dl_freq), .dl_gray(dl_gray), .busy(busy), .done(done), .fail(fail)
   );

   // Delay-line model: clock-out status lags the enable, lock after a short settle
   logic [2:0] clk_dly = '0;
   int         lock_cnt = 0;
   bit         stuck_hi = 1'b0, stuck_lo = 1'b0, no_lock = 1'b0;

   always @(posedge clk) begin
      clk_dly <= {clk_dly[1:0], dl_clkout_en};
      if (dl_en && dl_clkout_en && !dl_rst && !dl_pdn) lock_cnt <= (lock_cnt < 10) ? lock_cnt + 1 : lock_cnt;
      else lock_cnt <= 0;
   end
   assign clkout_sts = stuck_hi ? 1'b1 : (stuck_lo ? 1'b0 : clk_dly[2]);
   assign lock_sts   = !no_lock && (lock_cnt >= 5);

   initial begin
      forever begin
         repeat (TICK_DIV - 1) @(negedge clk);
         us_tick = 1'b1;
         @(negedge clk);
         us_tick = 1'b0;
      end
   end

   task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic logic [7:0] enc(input int id, input int v);
      return 8'((id << 4) | v);
   endfunction

   // Scoreboard driver side: queue an expected change only if the value moves
   task automatic exp_sig(input int id, input int v, input string req);
      if (m_val[id] != v) begin
         exp_q.push_back('{enc(id, v), req});
         m_val[id] = v;
      end
   endtask

   task automatic exp_done(input bit f, input string req);
      exp_q.push_back('{enc(9, int'(f)), req});
   endtask

   task automatic mon_event(input int id, input int v);
      ev_t e;
      if (exp_q.size() == 0) begin
         check(1'b0, "R11", $sformatf("unexpected change id %0d", id), enc(id, v), 0);
      end else begin
         e = exp_q.pop_front();
         check(e.code == enc(id, v), e.req, "ordered output change", enc(id, v), e.code);
      end
   endtask

   // Monitor: sample away from the active edge, report changes in id order
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n) begin
            int cur[9];
            cur[0] = dl_psave;  cur[1] = dl_rst;  cur[2] = dl_pdn;
            cur[3] = dl_freq;   cur[4] = dl_en;   cur[5] = dl_clkout_en;
            cur[6] = dl_cdr_en; cur[7] = dl_cdr_ext_en; cur[8] = dl_gray;
            if (!mon_init) begin
               prv = cur;
               mon_init = 1'b1;
            end
            for (int id = 0; id < 9; id++) begin
               if (cur[id] != prv[id]) mon_event(id, cur[id]);
            end
            if (done) mon_event(9, int'(fail));
            prv = cur;
         end
      end
   end

   int op_cycles;

   task automatic wait_idle(input string req);
      int n = 0;
      op_cycles = 0;
      while (!done && n < 2000) begin
         @(negedge clk);
         n++;
         op_cycles++;
      end
      @(negedge clk);
      check(!done && !busy, "R12", "done one cycle and busy low after it", int'(done || busy), 0);
      repeat (3) @(negedge clk);
      check(exp_q.size() == 0, req, "expected events all seen", exp_q.size(), 0);
      exp_q.delete();
   endtask

   function automatic int exp_code(input int rate);
      int ceil[7] = '{112, 125, 137, 150, 162, 175, 187};
      for (int k = 0; k < 7; k++) if (rate <= ceil[k]) return k;
      return 7;
   endfunction

   task automatic run_init(input int rate, input bit lock_ok);
      int ps = m_val[0];
      no_lock = !lock_ok;
      exp_sig(0, 0, "R3");
      exp_sig(1, 1, "R3");
      exp_sig(2, 1, "R3");
      exp_sig(3, exp_code(rate), "R2");
      exp_sig(1, 0, "R3");
      exp_sig(2, 0, "R3");
      exp_sig(4, 1, "R3");
      exp_sig(5, 1, "R3");
      if (lock_ok) begin
         exp_sig(0, ps, "R6");
         exp_done(1'b0, "R4");
      end else begin
         exp_done(1'b1, "R5");
      end
      @(negedge clk);
      rate_mhz = 8'(rate);
      init_req = 1'b1;
      @(negedge clk);
      init_req = 1'b0;
      check(busy, "R12", "busy during init", int'(busy), 1);
      wait_idle(lock_ok ? "R4" : "R5");
      if (!lock_ok)
         check(op_cycles >= TO_US * TICK_DIV - TICK_DIV && op_cycles <= TO_US * TICK_DIV + 30,
               "R5", "lock timeout length", op_cycles, TO_US * TICK_DIV);
      no_lock = 1'b0;
   endtask

   task automatic run_phase(input int ph, input int mode);
      int gt[16] = '{0, 1, 3, 2, 6, 7, 5, 4, 12, 13, 15, 14, 10, 11, 9, 8};
      stuck_hi = (mode == 1);
      stuck_lo = (mode == 2);
      exp_sig(4, 1, "R7");
      exp_sig(5, 0, "R7");
      exp_sig(6, 0, "R7");
      exp_sig(7, 1, "R7");
      if (mode == 1) begin
         exp_done(1'b1, "R7");
      end else begin
         exp_sig(8, gt[ph], "R8");
         exp_sig(5, 1, "R9");
         if (mode == 2) begin
            exp_done(1'b1, "R9");
         end else begin
            exp_sig(6, 1, "R10");
            exp_sig(7, 0, "R10");
            exp_done(1'b0, "R10");
         end
      end
      @(negedge clk);
      phase_sel = 4'(ph);
      phase_req = 1'b1;
      @(negedge clk);
      phase_req = 1'b0;
      check(busy, "R12", "busy during phase load", int'(busy), 1);
      wait_idle(mode == 0 ? "R8" : (mode == 1 ? "R7" : "R9"));
      if (mode != 0)
         check(op_cycles >= TO_US * TICK_DIV - TICK_DIV && op_cycles <= TO_US * TICK_DIV + 30,
               mode == 1 ? "R7" : "R9", "clock-out wait timeout length", op_cycles, TO_US * TICK_DIV);
      stuck_hi = 1'b0;
      stuck_lo = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   task automatic load_psave(input bit v);
      exp_sig(0, int'(v), "R6");
      @(negedge clk);
      psave_val  = v;
      psave_load = 1'b1;
      @(negedge clk);
      psave_load = 1'b0;
      repeat (2) @(negedge clk);
      check(dl_psave == v, "R6", "power save loaded while idle", int'(dl_psave), int'(v));
      check(exp_q.size() == 0, "R6", "power save event seen", exp_q.size(), 0);
   endtask

   task automatic report();
      if (!finished) begin
         finished = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
   end

   initial begin
      for (int i = 0; i < 9; i++) m_val[i] = 0;
      repeat (3) @(negedge clk);
      // R1: reset values
      check({dl_rst, dl_pdn, dl_en, dl_clkout_en, dl_cdr_en, dl_cdr_ext_en, dl_psave} == 7'b0,
            "R1", "control outputs at reset",
            int'({dl_rst, dl_pdn, dl_en, dl_clkout_en, dl_cdr_en, dl_cdr_ext_en, dl_psave}), 0);
      check(dl_freq == 0 && dl_gray == 0, "R1", "code outputs at reset", int'({dl_freq, dl_gray}), 0);
      check(!busy && !done && !fail, "R1", "status at reset", int'({busy, done, fail}), 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      run_init(100, 1'b1);
      run_init(113, 1'b1);
      load_psave(1'b1);
      run_init(130, 1'b1);
      run_init(200, 1'b1);
      run_init(150, 1'b1);
      run_init(255, 1'b1);
      run_init(112, 1'b1);
      run_init(188, 1'b1);

      for (int ph = 0; ph < 16; ph++) run_phase(ph, 0);
      run_phase(5, 1);
      run_phase(9, 2);
      run_phase(2, 0);

      // R5 and R6: power save on before a bring-up that never locks stays off
      load_psave(1'b1);
      run_init(175, 1'b0);
      check(dl_psave == 1'b0, "R6", "power save not restored after failure", int'(dl_psave), 0);

      // R11: requests during a busy phase load are dropped
      run_phase_with_noise();

      // R11: simultaneous init and phase requests, init wins
      exp_sig(0, 0, "R11");
      exp_sig(1, 1, "R11");
      exp_sig(2, 1, "R11");
      exp_sig(3, exp_code(140), "R11");
      exp_sig(1, 0, "R11");
      exp_sig(2, 0, "R11");
      exp_sig(4, 1, "R11");
      exp_sig(5, 1, "R11");
      exp_done(1'b0, "R11");
      @(negedge clk);
      rate_mhz  = 8'd140;
      phase_sel = 4'd7;
      init_req  = 1'b1;
      phase_req = 1'b1;
      @(negedge clk);
      init_req  = 1'b0;
      phase_req = 1'b0;
      wait_idle("R11");

      report();
   end

   task automatic run_phase_with_noise();
      exp_sig(4, 1, "R11");
      exp_sig(5, 0, "R11");
      exp_sig(6, 0, "R11");
      exp_sig(7, 1, "R11");
      exp_sig(8, 5, "R11");
      exp_sig(5, 1, "R11");
      exp_sig(6, 1, "R11");
      exp_sig(7, 0, "R11");
      exp_done(1'b0, "R11");
      @(negedge clk);
      phase_sel = 4'd6;
      phase_req = 1'b1;
      @(negedge clk);
      phase_req = 1'b0;
      repeat (2) @(negedge clk);
      init_req   = 1'b1;
      psave_load = 1'b1;
      psave_val  = 1'b1;
      phase_req  = 1'b1;
      phase_sel  = 4'd15;
      @(negedge clk);
      init_req   = 1'b0;
      psave_load = 1'b0;
      phase_req  = 1'b0;
      wait_idle("R11");
      check(dl_psave == 1'b0, "R11", "power-save load ignored while busy", int'(dl_psave), 0);
   endtask

endmodule